// File: doc/BRIEF.md
# Aligned CIDR Prefix Remapping Allocator

This block gives every prefix of a routing table a stand-in network of the same size inside a 32-bit address space, so that a table and the traffic checked against it can be rewritten consistently. A table is streamed in over a valid/ready port as pairs of original prefix and mask length, closed by a last marker. The block then streams the table back out, one entry per transfer, each carrying the original prefix, its mask length and the newly assigned prefix.

Output order is set by network size. All entries of the longest mask come first, then the next longest, down to the shortest. Within one mask length the order is scrambled by a seeded linear feedback shift register. An allocation pointer hands each entry the lowest aligned block of its size at or above the pointer. Because sizes never shrink along the output stream, the space is packed without holes. If the space cannot hold an entry, that entry is flagged and allocation stops until reset.

Top module: `cidr_remap_alloc`

## Requirements
- R1: After reset is released, `out_valid` is 0, `exhausted` is 0 and `in_ready` is 1.
- R2: An entry is taken when `in_valid` and `in_ready` are both high. `in_len` must lie in 0..32. Loading ends with the entry that carries `in_last`, or with the 64th entry. From then on `in_ready` stays low until reset, and it is never high while `out_valid` is high.
- R3: Every loaded entry is emitted exactly once with its original prefix and mask length, unless allocation stops first (R7). Mask lengths along the output stream never increase.
- R4: The order among entries of equal mask length comes from a 16-bit LFSR seeded from `seed_i` while reset is high. A seed of zero acts as a seed of one. The same seed and the same loaded table give an identical output sequence.
- R5: An entry of mask length L is a block of 2^(32-L) addresses. The pointer starts at 0. The entry is placed at the smallest multiple of its block size that is not below the pointer, and the pointer then moves to the end of that block. For example, successive /30 entries land at 0x00000000, 0x00000004, 0x00000008.
- R6: Rounding up applies whenever the pointer is misaligned for a larger block. Four /30, then ten /24, then one /23 put the /23 at 0x00000C00.
- R7: If an aligned start plus block size exceeds 2^32, that entry is emitted with `out_err` = 1 and `out_new` = 0. `exhausted` rises with it and stays high, and no further entry is emitted until reset.
- R8: A /0 entry succeeds only when the pointer is still 0, and it then maps to 0x00000000. Any other /0 entry fails as in R7.
- R9: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_orig`, `out_len`, `out_new` and `out_err` hold their values.
- R10: Once the space is exactly full, the next entry fails. Three /1 entries give 0x00000000, 0x80000000, then a failed entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| seed_i | input | 16 | Shuffle seed, sampled while rst is high |
| in_valid | input | 1 | Input entry valid |
| in_ready | output | 1 | Block accepts an input entry |
| in_prefix | input | 32 | Original network prefix |
| in_len | input | 6 | Mask length, 0..32 |
| in_last | input | 1 | Marks the final entry of the table |
| out_valid | output | 1 | Output entry valid |
| out_ready | input | 1 | Consumer accepts the output entry |
| out_orig | output | 32 | Original prefix of the emitted entry |
| out_len | output | 6 | Mask length of the emitted entry |
| out_new | output | 32 | Assigned substitute prefix |
| out_err | output | 1 | Entry could not be placed |
| exhausted | output | 1 | Address space ran out; sticky until reset |

## Verification
Every result is tied to a handshake, not to a fixed delay. An input is taken at the first rising edge where `in_ready` is high. `in_ready` only changes on edges, so the bench reads it at the falling edge before that edge. Output latency depends on how many mask lengths the search must step through. For that reason the bench picks its `out_ready` value at each falling edge and records an entry only when `out_valid` is high in that same half cycle, which is exactly the transfer at the next rising edge. On a stalled cycle it compares the following falling edge against the held values. Expected addresses, order limits and output counts are rebuilt from the recorded mask lengths with a bench-side ceiling division. Reproducibility is checked by replaying a table under the same seed.

// File: rtl/cidr_remap_pkg.sv
package cidr_remap_pkg;
  typedef enum logic [2:0] {
    ST_LOAD,
    ST_SEARCH,
    ST_READ,
    ST_OUT,
    ST_DONE,
    ST_HALT
  } remap_state_e;
endpackage

// File: rtl/remap_lfsr.sv
module remap_lfsr #(
  parameter int          W    = 16,
  parameter logic [W-1:0] TAPS = 16'hB400
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] seed_i,
  input  logic         step_i,
  output logic [W-1:0] state_o
);
  logic [W-1:0] st_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q <= (seed_i == '0) ? W'(1) : seed_i;
    end else if (step_i) begin
      if (st_q[0]) st_q <= (st_q >> 1) ^ TAPS;
      else         st_q <= st_q >> 1;
    end
  end

  assign state_o = st_q;
endmodule

// File: rtl/remap_entry_store.sv
module remap_entry_store #(
  parameter int DEPTH = 64,
  parameter int DW    = 32,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          re_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we_i) mem[waddr_i] <= wdata_i;
    if (re_i) rdata_o <= mem[raddr_i];
  end
endmodule

// File: rtl/remap_picker.sv
module remap_picker #(
  parameter int DEPTH = 64,
  parameter int LW    = 6,
  parameter int RW    = 16,
  parameter int IDX_W = $clog2(DEPTH)
) (
  input  logic [DEPTH-1:0]         pend_i,
  input  logic [DEPTH-1:0][LW-1:0] lens_i,
  input  logic [LW-1:0]            want_i,
  input  logic [RW-1:0]            rnd_i,
  output logic                     hit_o,
  output logic [IDX_W-1:0]         idx_o
);
  logic [IDX_W-1:0] start;

  // fold every random bit into the start slot
  always_comb begin
    start = '0;
    for (int b = 0; b < RW; b++) begin
      start[b % IDX_W] = start[b % IDX_W] ^ rnd_i[b];
    end
  end

  // circular first-match search from the random start slot
  always_comb begin
    hit_o = 1'b0;
    idx_o = '0;
    for (int k = 0; k < DEPTH; k++) begin
      logic [IDX_W-1:0] cand;
      cand = start + IDX_W'(k);
      if (!hit_o && pend_i[cand] && (lens_i[cand] == want_i)) begin
        hit_o = 1'b1;
        idx_o = cand;
      end
    end
  end
endmodule

// File: rtl/remap_align.sv
module remap_align #(
  parameter int AW = 32,
  parameter int LW = 6,
  parameter int PW = AW + 2
) (
  input  logic [PW-1:0] ptr_i,
  input  logic [LW-1:0] len_i,
  output logic [PW-1:0] start_o,
  output logic [PW-1:0] next_o,
  output logic          ovf_o
);
  logic [PW-1:0] size_w;
  logic [PW-1:0] limit_w;

  always_comb begin
    size_w  = PW'(1) << (AW - int'(len_i));
    limit_w = PW'(1) << AW;
    start_o = (ptr_i + size_w - PW'(1)) & ~(size_w - PW'(1));
    next_o  = start_o + size_w;
    ovf_o   = next_o > limit_w;
  end
endmodule

// File: rtl/cidr_remap_alloc.sv
module cidr_remap_alloc
  import cidr_remap_pkg::*;
#(
  parameter int          AW    = 32,
  parameter int          LW    = 6,
  parameter int          DEPTH = 64,
  parameter int          RW    = 16,
  parameter logic [15:0] TAPS  = 16'hB400,
  parameter logic [31:0] BASE  = 32'h0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [RW-1:0] seed_i,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [AW-1:0] in_prefix,
  input  logic [LW-1:0] in_len,
  input  logic          in_last,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [AW-1:0] out_orig,
  output logic [LW-1:0] out_len,
  output logic [AW-1:0] out_new,
  output logic          out_err,
  output logic          exhausted
);
  localparam int IDX_W = $clog2(DEPTH);
  localparam int CW    = IDX_W + 1;
  localparam int PW    = AW + 2;

  remap_state_e             state_q;
  logic [CW-1:0]            cnt_q;
  logic [DEPTH-1:0][LW-1:0] len_q;
  logic [DEPTH-1:0]         pend_q;
  logic [LW-1:0]            cur_len_q;
  logic [IDX_W-1:0]         pick_q;
  logic [PW-1:0]            ptr_q;
  logic                     in_ready_q;

  logic                     take;
  logic                     hit;
  logic [IDX_W-1:0]         hit_idx;
  logic [RW-1:0]            rnd;
  logic                     rd_en;
  logic [AW-1:0]            rd_data;
  logic [PW-1:0]            al_start;
  logic [PW-1:0]            al_next;
  logic                     al_ovf;

  assign take  = (state_q == ST_LOAD) && in_valid && in_ready_q;
  assign rd_en = (state_q == ST_SEARCH) && hit;

  remap_lfsr #(.W(RW), .TAPS(TAPS)) lfsr_i (
    .clk(clk), .rst(rst), .seed_i(seed_i), .step_i(rd_en), .state_o(rnd)
  );

  remap_entry_store #(.DEPTH(DEPTH), .DW(AW)) store_i (
    .clk(clk), .we_i(take), .waddr_i(cnt_q[IDX_W-1:0]), .wdata_i(in_prefix),
    .re_i(rd_en), .raddr_i(hit_idx), .rdata_o(rd_data)
  );

  remap_picker #(.DEPTH(DEPTH), .LW(LW), .RW(RW)) pick_i (
    .pend_i(pend_q), .lens_i(len_q), .want_i(cur_len_q), .rnd_i(rnd),
    .hit_o(hit), .idx_o(hit_idx)
  );

  remap_align #(.AW(AW), .LW(LW), .PW(PW)) align_i (
    .ptr_i(ptr_q), .len_i(cur_len_q),
    .start_o(al_start), .next_o(al_next), .ovf_o(al_ovf)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_LOAD;
      cnt_q      <= '0;
      len_q      <= '0;
      pend_q     <= '0;
      cur_len_q  <= LW'(AW);
      pick_q     <= '0;
      ptr_q      <= PW'(BASE);
      in_ready_q <= 1'b1;
      out_valid  <= 1'b0;
      out_orig   <= '0;
      out_len    <= '0;
      out_new    <= '0;
      out_err    <= 1'b0;
      exhausted  <= 1'b0;
    end else begin
      case (state_q)
        ST_LOAD: begin
          if (take) begin
            len_q[cnt_q[IDX_W-1:0]]  <= in_len;
            pend_q[cnt_q[IDX_W-1:0]] <= 1'b1;
            cnt_q <= cnt_q + CW'(1);
            if (in_last || (cnt_q == CW'(DEPTH - 1))) begin
              in_ready_q <= 1'b0;
              cur_len_q  <= LW'(AW);
              state_q    <= ST_SEARCH;
            end
          end
        end
        ST_SEARCH: begin
          if (hit) begin
            pick_q  <= hit_idx;
            state_q <= ST_READ;
          end else if (cur_len_q == '0) begin
            state_q <= ST_DONE;
          end else begin
            cur_len_q <= cur_len_q - LW'(1);
          end
        end
        ST_READ: begin
          pend_q[pick_q] <= 1'b0;
          out_valid      <= 1'b1;
          out_orig       <= rd_data;
          out_len        <= cur_len_q;
          if (al_ovf) begin
            out_new   <= '0;
            out_err   <= 1'b1;
            exhausted <= 1'b1;
          end else begin
            out_new <= al_start[AW-1:0];
            out_err <= 1'b0;
            ptr_q   <= al_next;
          end
          state_q <= ST_OUT;
        end
        ST_OUT: begin
          if (out_ready) begin
            out_valid <= 1'b0;
            state_q   <= out_err ? ST_HALT : ST_SEARCH;
          end
        end
        default: begin
          state_q <= state_q;
        end
      endcase
    end
  end

  assign in_ready = in_ready_q;
endmodule

// File: rtl/remap_chk.sv
module remap_chk #(
  parameter int AW = 32,
  parameter int LW = 6
) (
  input logic          clk,
  input logic          rst,
  input logic          in_valid,
  input logic          in_ready,
  input logic [LW-1:0] in_len,
  input logic          out_valid,
  input logic          out_ready,
  input logic [AW-1:0] out_orig,
  input logic [LW-1:0] out_len,
  input logic [AW-1:0] out_new,
  input logic          out_err,
  input logic          exhausted
);
  localparam int PW = AW + 2;

  logic          seen_q;
  logic [LW-1:0] last_len_q;
  logic [PW-1:0] last_end_q;

  function automatic logic [PW-1:0] blk(input logic [LW-1:0] l);
    return PW'(1) << (AW - int'(l));
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      seen_q     <= 1'b0;
      last_len_q <= '0;
      last_end_q <= '0;
    end else if (out_valid && out_ready) begin
      seen_q     <= 1'b1;
      last_len_q <= out_len;
      last_end_q <= PW'(out_new) + blk(out_len);
    end
  end

  // R2
  len_range_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid && in_ready |-> in_len <= LW'(AW));
  // R2
  load_excl_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> !in_ready);
  // R3
  order_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid && seen_q |-> out_len <= last_len_q);
  // R5
  align_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_err |-> ((PW'(out_new) & (blk(out_len) - PW'(1))) == '0));
  // R5
  pack_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_err && seen_q |-> PW'(out_new) >= last_end_q);
  // R9
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_orig) && $stable(out_len)
      && $stable(out_new) && $stable(out_err));
  // R7
  err_flag_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_err |-> exhausted);
  // R7
  sticky_chk: assert property (@(posedge clk) disable iff (rst)
    exhausted |=> exhausted);
  // R7
  quiet_chk: assert property (@(posedge clk) disable iff (rst)
    exhausted && !out_valid |=> !out_valid);
endmodule

bind cidr_remap_alloc remap_chk #(.AW(AW), .LW(LW)) chk_i (.*);

// File: tb/cidr_remap_alloc_tb_top.sv
module cidr_remap_alloc_tb_top;
  logic        clk = 1'b0;
  logic        rst;
  logic [15:0] seed_i;
  logic        in_valid, in_ready, in_last;
  logic [31:0] in_prefix;
  logic [5:0]  in_len;
  logic        out_valid, out_ready, out_err, exhausted;
  logic [31:0] out_orig, out_new;
  logic [5:0]  out_len;

  always #4 clk = ~clk;

  cidr_remap_alloc dut_i (
    .clk(clk), .rst(rst), .seed_i(seed_i),
    .in_valid(in_valid), .in_ready(in_ready), .in_prefix(in_prefix),
    .in_len(in_len), .in_last(in_last),
    .out_valid(out_valid), .out_ready(out_ready), .out_orig(out_orig),
    .out_len(out_len), .out_new(out_new), .out_err(out_err),
    .exhausted(exhausted)
  );

  int tests = 0;
  int fails = 0;
  int cyc   = 0;

  logic [31:0] ld_p [64];
  int          ld_l [64];
  int          ld_n;
  logic [31:0] rc_p [64];
  int          rc_l [64];
  logic [31:0] rc_n [64];
  bit          rc_e [64];
  int          rc_cnt;
  logic [31:0] sv_p [64];
  logic [31:0] sv_n [64];
  int          sv_cnt;

  task automatic report();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 190000) begin
      fails++;
      $display("FAIL watchdog: run did not complete (actual cycles=%0d expected<190000)", cyc);
      report();
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic do_reset(input logic [15:0] s);
    rst = 1'b1; seed_i = s; in_valid = 1'b0; in_last = 1'b0;
    in_prefix = '0; in_len = '0; out_ready = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
  endtask

  task automatic push(input logic [31:0] p, input int l, input bit last);
    in_valid = 1'b1; in_prefix = p; in_len = 6'(l); in_last = last;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0; in_last = 1'b0;
  endtask

  task automatic load_table(input bit use_last);
    for (int i = 0; i < ld_n; i++) push(ld_p[i], ld_l[i], use_last && (i == ld_n - 1));
  endtask

  // expected number of emitted entries, walking sizes longest mask first
  function automatic int exp_count();
    longint ptr = 0;
    int n = 0;
    for (int l = 32; l >= 0; l--) begin
      for (int i = 0; i < ld_n; i++) begin
        if (ld_l[i] == l) begin
          longint sz = longint'(1) << (32 - l);
          longint st = ((ptr + sz - 1) / sz) * sz;
          n++;
          if (st + sz > (longint'(1) << 32)) return n;
          ptr = st + sz;
        end
      end
    end
    return n;
  endfunction

  task automatic drain(input int expect_n, input int pct);
    bit          hold = 0;
    logic [31:0] h_p, h_n;
    int          h_l;
    bit          h_e;
    int          bad = 0;
    int          extra = 0;
    int          guard = 0;
    rc_cnt = 0;
    while (rc_cnt < expect_n && guard < 20000) begin
      bit r;
      guard++;
      if (hold && !(out_valid && out_orig == h_p && out_new == h_n &&
                    int'(out_len) == h_l && out_err == h_e)) bad++;
      r = (($urandom % 100) < pct);
      if (out_valid && r) begin
        rc_p[rc_cnt] = out_orig; rc_l[rc_cnt] = int'(out_len);
        rc_n[rc_cnt] = out_new;  rc_e[rc_cnt] = out_err;
        rc_cnt++;
      end
      hold = out_valid && !r;
      h_p = out_orig; h_n = out_new; h_l = int'(out_len); h_e = out_err;
      out_ready = r;
      @(negedge clk);
    end
    out_ready = 1'b1;
    repeat (80) begin
      if (out_valid) extra++;
      @(negedge clk);
    end
    out_ready = 1'b0;
    check(bad == 0, "R9", "held output changed while stalled (count)", bad, 0);
    check(rc_cnt == expect_n, "R3", "emitted entry count", rc_cnt, expect_n);
    check(extra == 0, "R7", "entries beyond expected end", extra, 0);
    check(in_ready == 1'b0, "R2", "in_ready after load", in_ready, 0);
  endtask

  task automatic verify();
    longint ptr = 0;
    int     prev = 33;
    bit     used [64];
    bit     any_err = 0;
    int     bad_ord = 0, bad_set = 0, bad_addr = 0;
    for (int i = 0; i < 64; i++) used[i] = 0;
    for (int i = 0; i < rc_cnt; i++) begin
      longint sz = longint'(1) << (32 - rc_l[i]);
      longint st = ((ptr + sz - 1) / sz) * sz;
      bit     found = 0;
      if (rc_l[i] > prev) bad_ord++;
      prev = rc_l[i];
      for (int j = 0; j < ld_n; j++) begin
        if (!found && !used[j] && ld_p[j] == rc_p[i] && ld_l[j] == rc_l[i]) begin
          used[j] = 1; found = 1;
        end
      end
      if (!found) bad_set++;
      if (st + sz > (longint'(1) << 32)) begin
        any_err = 1;
        check(rc_e[i] && rc_n[i] == 0, "R7", "failed entry flag/new", {rc_e[i], rc_n[i]}, 33'h100000000);
      end else begin
        if (rc_e[i] || longint'(rc_n[i]) != st) begin
          bad_addr++;
          $display("FAIL R5 entry %0d len %0d actual=%0h expected=%0h", i, rc_l[i], rc_n[i], st);
        end
        ptr = st + sz;
      end
    end
    tests++;
    if (bad_addr != 0) fails++;
    check(bad_ord == 0, "R3", "mask length increase count", bad_ord, 0);
    check(bad_set == 0, "R3", "entries not matching loaded table", bad_set, 0);
    check(exhausted == any_err, "R7", "exhausted flag", exhausted, any_err);
  endtask

  task automatic run(input logic [15:0] s, input int pct);
    do_reset(s);
    load_table(1);
    drain(exp_count(), pct);
    verify();
  endtask

  initial begin
    void'($urandom(32'd7531));

    // R1 reset state
    do_reset(16'h00A5);
    check(out_valid == 0, "R1", "out_valid after reset", out_valid, 0);
    check(exhausted == 0, "R1", "exhausted after reset", exhausted, 0);
    check(in_ready == 1, "R1", "in_ready after reset", in_ready, 1);

    // R5 R6 mixed /30, /24, /23 in scattered order
    ld_n = 0;
    for (int i = 0; i < 15; i++) begin
      int l = (i % 3 == 0 && ld_n < 12) ? 30 : 24;
      ld_p[i] = $urandom; ld_l[i] = 24; ld_n++;
      if (i == 1 || i == 4 || i == 8 || i == 13) ld_l[i] = 30;
      if (i == 6) ld_l[i] = 23;
      if (l == 0) ld_l[i] = 0;
    end
    run(16'h3C3C, 60);
    for (int i = 0; i < rc_cnt; i++) begin
      if (rc_l[i] == 23) check(rc_n[i] == 32'h00000C00, "R6", "/23 start", rc_n[i], 32'hC00);
      if (i < 4) check(rc_l[i] == 30 && rc_n[i] == 32'(4 * i), "R5", "/30 start", rc_n[i], 4 * i);
    end

    // R10 three /1 entries
    ld_n = 3;
    for (int i = 0; i < 3; i++) begin ld_p[i] = $urandom; ld_l[i] = 1; end
    run(16'h0101, 100);
    check(rc_cnt == 3 && rc_n[0] == 32'h0 && rc_n[1] == 32'h80000000 && rc_e[2],
          "R10", "third /1 fails", rc_n[1], 32'h80000000);

    // R8 sole /0 entry
    ld_n = 1; ld_p[0] = 32'h0A000000; ld_l[0] = 0;
    run(16'h0022, 100);
    check(rc_cnt == 1 && !rc_e[0] && rc_n[0] == 0, "R8", "sole /0 maps to 0", rc_e[0], 0);

    // R8 /0 after a /32
    ld_n = 2; ld_p[0] = 32'h0B000000; ld_l[0] = 0; ld_p[1] = 32'h01020304; ld_l[1] = 32;
    run(16'h0033, 50);
    check(rc_cnt == 2 && rc_l[0] == 32 && rc_n[0] == 0 && rc_e[1], "R8", "/0 after /32 fails",
          rc_e[1], 1);

    // R2 full table with no last marker
    do_reset(16'h4444);
    ld_n = 64;
    for (int i = 0; i < 64; i++) begin ld_p[i] = $urandom; ld_l[i] = 26 + ($urandom % 7); end
    load_table(0);
    check(in_ready == 0, "R2", "in_ready after 64 entries", in_ready, 0);
    drain(64, 70);
    verify();

    // R4 reproducibility with the same seed, and zero seed acting as one
    ld_n = 30;
    for (int i = 0; i < 30; i++) begin ld_p[i] = $urandom; ld_l[i] = (i % 2) ? 28 : 30; end
    run(16'h1234, 40);
    sv_cnt = rc_cnt;
    for (int i = 0; i < rc_cnt; i++) begin sv_p[i] = rc_p[i]; sv_n[i] = rc_n[i]; end
    run(16'h1234, 90);
    begin
      int mism = (rc_cnt != sv_cnt) ? 1 : 0;
      for (int i = 0; i < rc_cnt; i++) if (sv_p[i] != rc_p[i] || sv_n[i] != rc_n[i]) mism++;
      check(mism == 0, "R4", "same seed sequence mismatches", mism, 0);
    end
    run(16'h0000, 80);
    sv_cnt = rc_cnt;
    for (int i = 0; i < rc_cnt; i++) begin sv_p[i] = rc_p[i]; sv_n[i] = rc_n[i]; end
    run(16'h0001, 30);
    begin
      int mism = (rc_cnt != sv_cnt) ? 1 : 0;
      for (int i = 0; i < rc_cnt; i++) if (sv_p[i] != rc_p[i] || sv_n[i] != rc_n[i]) mism++;
      check(mism == 0, "R4", "zero seed vs seed one mismatches", mism, 0);
    end

    // R3 R5 random tables
    for (int t = 0; t < 8; t++) begin
      ld_n = 1 + ($urandom % 64);
      for (int i = 0; i < ld_n; i++) begin ld_p[i] = $urandom; ld_l[i] = 18 + ($urandom % 15); end
      run(16'($urandom), 30 + ($urandom % 71));
    end

    report();
    $finish;
  end
endmodule